// File: doc/BRIEF.md
# Time-Shared Cascaded Biquad Filter

This block filters a stream of 16-bit signed samples through four second-order recursive sections in series. It has one multiplier and one accumulator. A fast processing clock runs a fixed microcoded schedule of multiply-accumulate steps for every accepted sample. The schedule visits each section in turn. Each section's result becomes the input of the next, and the last result is the block output.

Coefficients live in one small inferred RAM. The per-section history lives in a second one. Both have a one-cycle write and a registered one-cycle read. The sequencer issues each read address one cycle before the multiplier needs the word, which hides the read latency. Coefficients are loaded through a plain address/data/enable write port while the engine is idle.

Each section runs for 7 cycles, so a whole sample takes 28 processing cycles. The processing clock must therefore run at least 29 times faster than the sample rate.

Top module: `biquad_cascade`

## Requirements
- R1: During and after synchronous reset, `out_valid`, `overrun` and `out_sample` are 0. After reset the block spends 16 cycles writing zero to every history word. The first sample accepted afterwards is filtered against an all-zero history.
- R2: Each section computes y = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2 in direct form I. After that, x1 and x2 hold the last two section inputs and y1 and y2 hold the last two section outputs. The input sample feeds section 0, section s feeds section s+1, and the section 3 result is `out_sample`.
- R3: Coefficients are signed 18-bit with 14 fractional bits (16384 = 1.0). The word for section s, tap k sits at write address 5·s + k, with k = 0:b0, 1:b1, 2:b2, 3:a1, 4:a2. The two a-terms are subtracted.
- R4: Every section result is formed as (sum + 8192) shifted right by 14 with sign. It is then clamped to the range −32768 … 32767, and the clamped value is what feeds the next section and the history.
- R5: `out_valid` is a single-cycle pulse. It rises at the 28th rising clock edge after the edge that accepted `in_valid`. A sample is accepted in any cycle in which no schedule is running, and this includes the cycle in which `out_valid` is high.
- R6: An `in_valid` that arrives while a schedule or the reset sweep is running is dropped: it produces no output and leaves the history untouched. It also sets `overrun`, which stays 1 until reset.
- R7: A coefficient write taken while the engine is idle is used from the next accepted sample on. A write presented while a schedule is running is ignored.
- R8: `out_sample` holds its value between `out_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample strobe, one cycle |
| out_sample | output | 16 | Signed filtered sample |
| overrun | output | 1 | Sticky flag: an input sample was dropped |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | 5 | Coefficient address, 5·section + tap |
| cw_data | input | 18 | Signed coefficient, 14 fractional bits |

## Verification
The embedded assertions watch properties that hold on every cycle:
- the output strobe lasts one cycle and arrives exactly 28 cycles after acceptance;
- the overrun flag only rises after an input strobe and never falls;
- no history word is written and read in the same cycle;
- accumulation only continues a chain that a load started.

The arithmetic itself can only be shown by the bench's scenarios, which compare every output with a bench-side fixed-point model. This covers rounding direction, per-section clamping, tap ordering, feedback recursion, and whether dropped samples and ignored coefficient writes really leave no trace.

// File: rtl/biquad_pkg.sv
package biquad_pkg;

    localparam int TAPS  = 5;   // b0 b1 b2 a1 a2
    localparam int HIST  = 4;   // x1 x2 y1 y2
    localparam int STEPS = 7;   // cycles per section

    localparam logic [1:0] SLOT_X1 = 2'd0;
    localparam logic [1:0] SLOT_X2 = 2'd1;
    localparam logic [1:0] SLOT_Y1 = 2'd2;
    localparam logic [1:0] SLOT_Y2 = 2'd3;

    typedef enum logic [1:0] {
        ENG_CLEAR,
        ENG_IDLE,
        ENG_RUN
    } eng_t;

    typedef enum logic [1:0] {
        WSRC_X1OLD,
        WSRC_XIN,
        WSRC_Y1OLD,
        WSRC_YNEW
    } wsrc_t;

    typedef struct packed {
        logic       rd_en;      // fetch coefficient word
        logic [2:0] tap;        // coefficient index within section
        logic       rd_state;   // fetch history word too
        logic [1:0] rd_slot;
        logic       mac_en;
        logic       mac_load;   // first product of a section
        logic       mac_sub;    // feedback term
        logic       op_x;       // operand is the section input register
        logic       cap_x1;
        logic       cap_y1;
        logic       wr_en;
        logic [1:0] wr_slot;
        wsrc_t      wr_src;
        logic       sect_done;
    } uop_t;

    // Microcode for one section. Reads are issued one step ahead of the MAC.
    function automatic uop_t step_uop(input logic [2:0] step);
        uop_t u;
        u = '0;
        case (step)
            3'd0: begin
                u.rd_en = 1'b1; u.tap = 3'd0;
            end
            3'd1: begin
                u.rd_en = 1'b1; u.tap = 3'd1; u.rd_state = 1'b1; u.rd_slot = SLOT_X1;
                u.mac_en = 1'b1; u.mac_load = 1'b1; u.op_x = 1'b1;
            end
            3'd2: begin
                u.rd_en = 1'b1; u.tap = 3'd2; u.rd_state = 1'b1; u.rd_slot = SLOT_X2;
                u.mac_en = 1'b1; u.cap_x1 = 1'b1;
            end
            3'd3: begin
                u.rd_en = 1'b1; u.tap = 3'd3; u.rd_state = 1'b1; u.rd_slot = SLOT_Y1;
                u.mac_en = 1'b1;
                u.wr_en = 1'b1; u.wr_slot = SLOT_X2; u.wr_src = WSRC_X1OLD;
            end
            3'd4: begin
                u.rd_en = 1'b1; u.tap = 3'd4; u.rd_state = 1'b1; u.rd_slot = SLOT_Y2;
                u.mac_en = 1'b1; u.mac_sub = 1'b1; u.cap_y1 = 1'b1;
                u.wr_en = 1'b1; u.wr_slot = SLOT_X1; u.wr_src = WSRC_XIN;
            end
            3'd5: begin
                u.mac_en = 1'b1; u.mac_sub = 1'b1;
                u.wr_en = 1'b1; u.wr_slot = SLOT_Y2; u.wr_src = WSRC_Y1OLD;
            end
            3'd6: begin
                u.wr_en = 1'b1; u.wr_slot = SLOT_Y1; u.wr_src = WSRC_YNEW;
                u.sect_done = 1'b1;
            end
            default: u = '0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/bq_ram.sv
module bq_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/bq_mac.sv
module bq_mac #(
    parameter int COEF_W = 18,
    parameter int SAMP_W = 16,
    parameter int ACC_W  = 48,
    parameter int FRAC   = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     load,
    input  logic                     sub,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [SAMP_W-1:0] operand,
    output logic signed [SAMP_W-1:0] y
);

    localparam int PROD_W = COEF_W + SAMP_W;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (FRAC - 1));
    localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((64'sd1 <<< (SAMP_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SMIN = -SMAX - ACC_W'(64'sd1);

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  term;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  rounded;
    logic signed [ACC_W-1:0]  shifted;

    always_comb begin
        prod     = coef * operand;
        prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
        term     = sub ? -prod_ext : prod_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= load ? term : acc_q + term;
        end
    end

    always_comb begin
        rounded = acc_q + HALF;
        shifted = rounded >>> FRAC;
        if (shifted > SMAX) begin
            y = SMAX[SAMP_W-1:0];
        end else if (shifted < SMIN) begin
            y = SMIN[SAMP_W-1:0];
        end else begin
            y = shifted[SAMP_W-1:0];
        end
    end

    // R2: accumulation only continues a chain started by a load
    assert_mac_chain_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |-> $past(en))
        else $error("accumulate without a preceding MAC step");

endmodule

// File: rtl/bq_sequencer.sv
module bq_sequencer
    import biquad_pkg::*;
#(
    parameter int NUM_SECT = 4,
    parameter int CA_W     = 5,
    parameter int SA_W     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            cw_en,
    input  logic [CA_W-1:0] cw_addr,
    output logic            accept,
    output logic            coef_we,
    output logic            coef_re,
    output logic [CA_W-1:0] coef_raddr,
    output logic            st_we,
    output logic [SA_W-1:0] st_waddr,
    output logic            st_re,
    output logic [SA_W-1:0] st_raddr,
    output logic            clearing,
    output wsrc_t           wr_src,
    output logic            mac_en,
    output logic            mac_load,
    output logic            mac_sub,
    output logic            op_x,
    output logic            cap_x1,
    output logic            cap_y1,
    output logic            sect_done,
    output logic            last_done,
    output logic            out_valid,
    output logic            overrun
);

    localparam int SEC_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
    localparam int NCOEF   = NUM_SECT * TAPS;
    localparam int NSTATE  = NUM_SECT * HIST;

    eng_t             eng_q;
    logic [SEC_W-1:0] sect_q;
    logic [2:0]       step_q;
    logic [SA_W-1:0]  clr_q;
    uop_t             u;
    logic             last_sect;
    logic             last_step;

    always_comb begin
        u         = (eng_q == ENG_RUN) ? step_uop(step_q) : '0;
        last_sect = (sect_q == SEC_W'(NUM_SECT - 1));
        last_step = (step_q == 3'(STEPS - 1));
        accept    = (eng_q == ENG_IDLE) && in_valid;
        clearing  = (eng_q == ENG_CLEAR);
        coef_we   = cw_en && (eng_q == ENG_IDLE) && (32'(cw_addr) < NCOEF);
        coef_re   = u.rd_en;
        coef_raddr = CA_W'(32'(sect_q) * TAPS + 32'(u.tap));
        st_re     = u.rd_en && u.rd_state;
        st_raddr  = SA_W'(32'(sect_q) * HIST + 32'(u.rd_slot));
        st_we     = clearing || u.wr_en;
        st_waddr  = clearing ? clr_q : SA_W'(32'(sect_q) * HIST + 32'(u.wr_slot));
        wr_src    = u.wr_src;
        mac_en    = u.mac_en;
        mac_load  = u.mac_load;
        mac_sub   = u.mac_sub;
        op_x      = u.op_x;
        cap_x1    = u.cap_x1;
        cap_y1    = u.cap_y1;
        sect_done = u.sect_done;
        last_done = u.sect_done && last_sect;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_q     <= ENG_CLEAR;
            sect_q    <= '0;
            step_q    <= '0;
            clr_q     <= '0;
            out_valid <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid && (eng_q != ENG_IDLE)) begin
                overrun <= 1'b1;
            end
            case (eng_q)
                ENG_CLEAR: begin
                    clr_q <= clr_q + 1'b1;
                    if (clr_q == SA_W'(NSTATE - 1)) begin
                        eng_q <= ENG_IDLE;
                    end
                end
                ENG_IDLE: begin
                    if (in_valid) begin
                        eng_q  <= ENG_RUN;
                        sect_q <= '0;
                        step_q <= '0;
                    end
                end
                ENG_RUN: begin
                    if (last_step) begin
                        step_q <= '0;
                        if (last_sect) begin
                            eng_q     <= ENG_IDLE;
                            out_valid <= 1'b1;
                        end else begin
                            sect_q <= sect_q + 1'b1;
                        end
                    end else begin
                        step_q <= step_q + 3'd1;
                    end
                end
                default: eng_q <= ENG_CLEAR;
            endcase
        end
    end

    // R5: the output strobe lasts one cycle
    assert_out_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid)
        else $error("out_valid longer than one cycle");

    // R6: overrun never falls outside reset
    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun)
        else $error("overrun cleared without reset");

    // R6: overrun only rises after an input strobe
    assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(in_valid))
        else $error("overrun set without input strobe");

    // R2: no history word is written and read in the same cycle
    assert_no_clash_R2: assert property (@(posedge clk) disable iff (rst)
        (st_we && st_re) |-> (st_waddr != st_raddr))
        else $error("history read/write collision");

endmodule

// File: rtl/biquad_cascade.sv
module biquad_cascade
    import biquad_pkg::*;
#(
    parameter int NUM_SECT = 4,
    parameter int SAMP_W   = 16,
    parameter int COEF_W   = 18,
    parameter int FRAC     = 14,
    parameter int ACC_W    = 48
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    input  logic [SAMP_W-1:0]                    in_sample,
    output logic                                 out_valid,
    output logic [SAMP_W-1:0]                    out_sample,
    output logic                                 overrun,
    input  logic                                 cw_en,
    input  logic [$clog2(NUM_SECT*TAPS)-1:0]     cw_addr,
    input  logic [COEF_W-1:0]                    cw_data
);

    localparam int NCOEF  = NUM_SECT * TAPS;
    localparam int NSTATE = NUM_SECT * HIST;
    localparam int CA_W   = $clog2(NCOEF);
    localparam int SA_W   = $clog2(NSTATE);
    localparam int LAT    = NUM_SECT * STEPS;
    localparam int LC_W   = $clog2(LAT + 1) + 1;

    logic              accept, coef_we, coef_re, st_we, st_re, clearing;
    logic [CA_W-1:0]   coef_raddr;
    logic [SA_W-1:0]   st_waddr, st_raddr;
    wsrc_t             wr_src;
    logic              mac_en, mac_load, mac_sub, op_x, cap_x1, cap_y1;
    logic              sect_done, last_done;

    logic signed [COEF_W-1:0] coef_rdata;
    logic signed [SAMP_W-1:0] st_rdata;
    logic signed [SAMP_W-1:0] st_wdata;
    logic signed [SAMP_W-1:0] operand;
    logic signed [SAMP_W-1:0] y_sec;
    logic signed [SAMP_W-1:0] x_q, x1_old_q, y1_old_q;

    bq_sequencer #(
        .NUM_SECT(NUM_SECT),
        .CA_W    (CA_W),
        .SA_W    (SA_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .cw_en     (cw_en),
        .cw_addr   (cw_addr),
        .accept    (accept),
        .coef_we   (coef_we),
        .coef_re   (coef_re),
        .coef_raddr(coef_raddr),
        .st_we     (st_we),
        .st_waddr  (st_waddr),
        .st_re     (st_re),
        .st_raddr  (st_raddr),
        .clearing  (clearing),
        .wr_src    (wr_src),
        .mac_en    (mac_en),
        .mac_load  (mac_load),
        .mac_sub   (mac_sub),
        .op_x      (op_x),
        .cap_x1    (cap_x1),
        .cap_y1    (cap_y1),
        .sect_done (sect_done),
        .last_done (last_done),
        .out_valid (out_valid),
        .overrun   (overrun)
    );

    bq_ram #(
        .W    (COEF_W),
        .DEPTH(NCOEF),
        .AW   (CA_W)
    ) u_coef_ram (
        .clk  (clk),
        .we   (coef_we),
        .waddr(cw_addr),
        .wdata(cw_data),
        .re   (coef_re),
        .raddr(coef_raddr),
        .rdata(coef_rdata)
    );

    bq_ram #(
        .W    (SAMP_W),
        .DEPTH(NSTATE),
        .AW   (SA_W)
    ) u_hist_ram (
        .clk  (clk),
        .we   (st_we),
        .waddr(st_waddr),
        .wdata(st_wdata),
        .re   (st_re),
        .raddr(st_raddr),
        .rdata(st_rdata)
    );

    bq_mac #(
        .COEF_W(COEF_W),
        .SAMP_W(SAMP_W),
        .ACC_W (ACC_W),
        .FRAC  (FRAC)
    ) u_mac (
        .clk    (clk),
        .rst    (rst),
        .en     (mac_en),
        .load   (mac_load),
        .sub    (mac_sub),
        .coef   (coef_rdata),
        .operand(operand),
        .y      (y_sec)
    );

    always_comb begin
        operand = op_x ? x_q : st_rdata;
        if (clearing) begin
            st_wdata = '0;
        end else begin
            case (wr_src)
                WSRC_X1OLD: st_wdata = x1_old_q;
                WSRC_XIN:   st_wdata = x_q;
                WSRC_Y1OLD: st_wdata = y1_old_q;
                default:    st_wdata = y_sec;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q        <= '0;
            x1_old_q   <= '0;
            y1_old_q   <= '0;
            out_sample <= '0;
        end else begin
            if (accept) begin
                x_q <= in_sample;
            end else if (sect_done) begin
                x_q <= y_sec;
            end
            if (cap_x1) begin
                x1_old_q <= st_rdata;
            end
            if (cap_y1) begin
                y1_old_q <= st_rdata;
            end
            if (last_done) begin
                out_sample <= y_sec;
            end
        end
    end

    // Checker counter: cycles since the last accepted sample
    logic [LC_W-1:0] since_accept_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_accept_q <= '1;
        end else if (accept) begin
            since_accept_q <= '0;
        end else if (since_accept_q != '1) begin
            since_accept_q <= since_accept_q + 1'b1;
        end
    end

    // R5: output strobe arrives exactly LAT edges after acceptance
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (since_accept_q == LC_W'(LAT)))
        else $error("output strobe at wrong latency");

endmodule

// File: tb/biquad_cascade_test.sv
module biquad_cascade_test;

    localparam int LAT = 28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        out_valid;
    logic [15:0] out_sample;
    logic        overrun;
    logic        cw_en = 1'b0;
    logic [4:0]  cw_addr = '0;
    logic [17:0] cw_data = '0;

    int checks = 0;
    int errors = 0;
    int mcoef [20];
    int mst   [16];
    int seed  = 32'h1234_5678;

    always #10 clk = ~clk;

    biquad_cascade uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_sample(out_sample),
        .overrun   (overrun),
        .cw_en     (cw_en),
        .cw_addr   (cw_addr),
        .cw_data   (cw_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // Reference model built from R2, R3, R4
    function automatic int model_run(input int xin);
        int x;
        x = xin;
        for (int s = 0; s < 4; s++) begin
            longint acc;
            int y;
            acc = longint'(mcoef[s*5+0]) * x
                + longint'(mcoef[s*5+1]) * mst[s*4+0]
                + longint'(mcoef[s*5+2]) * mst[s*4+1]
                - longint'(mcoef[s*5+3]) * mst[s*4+2]
                - longint'(mcoef[s*5+4]) * mst[s*4+3];
            y = sat16((acc + 64'sd8192) >>> 14);
            mst[s*4+1] = mst[s*4+0];
            mst[s*4+0] = x;
            mst[s*4+3] = mst[s*4+2];
            mst[s*4+2] = y;
            x = y;
        end
        return x;
    endfunction

    function automatic int rnd(input int span);
        int v;
        seed = seed * 1103515245 + 12345;
        v = (seed >>> 8) & 32'h007f_ffff;
        return (v % (2 * span + 1)) - span;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) mst[i] = 0;
        repeat (20) @(negedge clk);
    endtask

    task automatic load(input int s, input int k, input int v);
        @(negedge clk);
        cw_en   = 1'b1;
        cw_addr = 5'(s * 5 + k);
        cw_data = 18'(v);
        @(negedge clk);
        cw_en = 1'b0;
        mcoef[s*5+k] = v;
    endtask

    task automatic load_identity();
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 5; k++) begin
                load(s, k, (k == 0) ? 16384 : 0);
            end
        end
    endtask

    // Present one sample and wait for its result; lat counts rising edges
    task automatic send(input int x, input bit now, output int got, output int lat);
        if (!now) @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 16'(x);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        while (!out_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        got = int'($signed(out_sample));
    endtask

    task automatic count_pulses(input int cycles, output int n, output int last);
        n = 0;
        last = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (out_valid) begin
                n++;
                last = int'($signed(out_sample));
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog R5 actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int got, lat, exp, n, last;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 out_sample", int'($signed(out_sample)), 0);
        for (int i = 0; i < 16; i++) mst[i] = 0;
        repeat (20) @(negedge clk);

        // R2 R3 R5: identity cascade across the input range
        load_identity();
        for (int x = -32768; x <= 32767; x += 3277) begin
            send(x, 1'b0, got, lat);
            exp = model_run(x);
            chk("R2 identity", got, x);
            chk("R5 latency", lat, LAT);
        end
        send(32767, 1'b0, got, lat);
        exp = model_run(32767);
        chk("R2 identity max", got, 32767);

        // R5 pulse width, R8 hold
        @(negedge clk);
        chk("R5 single-cycle strobe", int'(out_valid), 0);
        repeat (10) @(negedge clk);
        chk("R8 output held", int'($signed(out_sample)), 32767);

        // R4: rounding with b0 = 0.5 in section 0
        load(0, 0, 8192);
        begin
            int xs [6] = '{3, -3, 1, -1, 5, -5};
            int es [6] = '{2, -1, 1, 0, 3, -2};
            for (int i = 0; i < 6; i++) begin
                send(xs[i], 1'b0, got, lat);
                exp = model_run(xs[i]);
                chk("R4 rounding", got, es[i]);
            end
        end

        // R4: per-section clamping (gain 4 then 0.25)
        load(0, 0, 65536);
        load(1, 0, 4096);
        send(10000, 1'b0, got, lat);
        exp = model_run(10000);
        chk("R4 clamp inside cascade +", got, 8192);
        send(-10000, 1'b0, got, lat);
        exp = model_run(-10000);
        chk("R4 clamp inside cascade -", got, -8192);
        load(1, 0, 16384);
        send(10000, 1'b0, got, lat);
        exp = model_run(10000);
        chk("R4 clamp output +", got, 32767);
        send(-10000, 1'b0, got, lat);
        exp = model_run(-10000);
        chk("R4 clamp output -", got, -32768);

        // R1 R3: feed-forward tap positions, history zero after reset
        do_reset();
        load(0, 0, 0);
        load(0, 1, 16384);
        send(100, 1'b0, got, lat); exp = model_run(100);
        chk("R1 zero history after reset", got, 0);
        send(200, 1'b0, got, lat); exp = model_run(200);
        chk("R3 b1 delay", got, 100);
        send(300, 1'b0, got, lat); exp = model_run(300);
        chk("R3 b1 delay", got, 200);
        load(0, 1, 0);
        load(0, 2, 16384);
        send(400, 1'b0, got, lat); exp = model_run(400);
        chk("R3 b2 delay", got, 200);
        send(500, 1'b0, got, lat); exp = model_run(500);
        chk("R3 b2 delay", got, 300);

        // R2 R3: feedback taps subtract (a1 = -0.5)
        do_reset();
        load(0, 2, 0);
        load(0, 0, 16384);
        load(0, 3, -8192);
        begin
            int xs [4] = '{1000, 0, 0, 0};
            int es [4] = '{1000, 500, 250, 125};
            for (int i = 0; i < 4; i++) begin
                send(xs[i], 1'b0, got, lat);
                exp = model_run(xs[i]);
                chk("R3 a1 feedback", got, es[i]);
            end
        end
        do_reset();
        load(0, 3, 0);
        load(0, 4, -8192);
        begin
            int xs [5] = '{1000, 0, 0, 0, 0};
            int es [5] = '{1000, 0, 500, 0, 250};
            for (int i = 0; i < 5; i++) begin
                send(xs[i], 1'b0, got, lat);
                exp = model_run(xs[i]);
                chk("R3 a2 feedback", got, es[i]);
            end
        end

        // R2 R4: sweep of coefficient sets against the model
        for (int set = 0; set < 6; set++) begin
            do_reset();
            for (int s = 0; s < 4; s++) begin
                load(s, 0, rnd(20000));
                load(s, 1, rnd(12000));
                load(s, 2, rnd(12000));
                load(s, 3, rnd(6000));
                load(s, 4, rnd(6000));
            end
            for (int i = 0; i < 12; i++) begin
                int x;
                x = (i == 0) ? 32767 : ((i == 1) ? -32768 : rnd(32767));
                send(x, 1'b0, got, lat);
                exp = model_run(x);
                chk("R2 model sweep", got, exp);
            end
        end

        // R5: back-to-back acceptance in the strobe cycle
        do_reset();
        load_identity();
        send(1234, 1'b0, got, lat);
        exp = model_run(1234);
        chk("R5 first", got, 1234);
        send(-4321, 1'b1, got, lat);
        exp = model_run(-4321);
        chk("R5 back-to-back value", got, -4321);
        chk("R5 back-to-back latency", lat, LAT);
        chk("R5 back-to-back no overrun", int'(overrun), 0);

        // R7: coefficient write during a running schedule is ignored
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = 16'(1000);
        @(negedge clk);
        in_valid = 1'b0;
        exp = model_run(1000);
        repeat (3) @(negedge clk);
        cw_en = 1'b1;
        cw_addr = 5'd0;
        cw_data = 18'(8192);
        @(negedge clk);
        cw_en = 1'b0;
        count_pulses(40, n, last);
        chk("R7 result during write", last, 1000);
        send(1000, 1'b0, got, lat);
        exp = model_run(1000);
        chk("R7 busy write ignored", got, 1000);
        load(0, 0, 8192);
        send(1000, 1'b0, got, lat);
        exp = model_run(1000);
        chk("R7 idle write applied", got, 500);
        load(0, 0, 16384);

        // R6: sample during a schedule is dropped and flagged
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = 16'(500);
        @(negedge clk);
        in_valid = 1'b0;
        exp = model_run(500);
        repeat (5) @(negedge clk);
        in_valid = 1'b1;
        in_sample = 16'(7000);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 overrun set", int'(overrun), 1);
        count_pulses(60, n, last);
        chk("R6 one output only", n, 1);
        chk("R6 output of kept sample", last, exp);
        send(2000, 1'b0, got, lat);
        exp = model_run(2000);
        chk("R6 dropped sample absent from history", got, exp);
        chk("R6 overrun sticky", int'(overrun), 1);

        // R1 R6: sample during the reset sweep is dropped
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) mst[i] = 0;
        chk("R1 overrun cleared", int'(overrun), 0);
        in_valid = 1'b1;
        in_sample = 16'(3000);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 overrun during sweep", int'(overrun), 1);
        count_pulses(50, n, last);
        chk("R6 no output during sweep", n, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule